// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is an 8-bit up-counter, driven by a selectable power-of-two prescaler, that sits on a simple synchronous register bus. When the counter wraps from 0xFF to 0x00 it does one of two things. In interval mode it raises a sticky flag and an interrupt line. In watchdog mode it sets a separate sticky flag and can emit a fixed-length reset pulse whose kind, one of two, is chosen by software. Software keeps the system alive by reloading the counter before it wraps.

The reset-control register is protected by keys. The upper byte of every 16-bit write to it must hold a key. One key value can only clear the watchdog flag. A second key value can only change the reset-enable and reset-kind bits. A write that carries any other upper byte does nothing. Reads need no key and are combinational from the address.

Top module: `kwdt_top`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_o`, `rst_pulse_o` and `rst_kind_o` are low.
- R2: Clock-select code CTRL[2:0] = 5, 6, 7 advances the counter once every 2^S, 2^(S+1), 2^(S+2) clocks (S = `BASE_SHIFT`, default 10, so 1024/2048/4096). Codes 0 to 4 behave as code 5. The first advance comes one full period after the counter is written.
- R3: While the run bit CTRL[3] is 0, the counter and the prescaler hold their values.
- R4: A write to address 1 loads bus_wdata[7:0] into the counter and restarts the prescaler phase, so a write of zero restarts the count from zero. This write takes priority over an advance in the same cycle.
- R5: In interval mode (CTRL[4] = 0), a wrap from 0xFF to 0x00 at a prescaler tick sets CTRL[7]. `irq_o` follows CTRL[7], and no reset pulse is produced.
- R6: CTRL[7] is sticky. A CTRL write with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it unchanged. If an overflow happens in the same cycle as a clearing write, the flag ends up set.
- R7: In watchdog mode (CTRL[4] = 1), a wrap sets RSTCTL[7] and leaves CTRL[7] and `irq_o` unchanged.
- R8: A write to RSTCTL (address 2) whose upper byte is 0xA5 clears RSTCTL[7] when bus_wdata[7] = 0. It never changes RSTCTL[6:5].
- R9: A write to RSTCTL whose upper byte is 0x5A loads RSTCTL[6] (reset enable) and RSTCTL[5] (reset kind) from bus_wdata[6:5]. It leaves RSTCTL[7] unchanged.
- R10: A write to RSTCTL with any other upper byte changes nothing.
- R11: A watchdog-mode wrap while RSTCTL[6] = 1 drives `rst_pulse_o` high for `PULSE_LEN` (128) clocks, starting in the cycle after the wrap edge. For the length of the pulse, `rst_kind_o` holds the RSTCTL[5] value seen at the wrap, and it is 0 at all other times. With RSTCTL[6] = 0 no pulse is produced.
- R12: `bus_rdata` is combinational from `bus_addr`. Address 0 returns {CTRL[7], 2'b00, CTRL[4:0]}, address 1 returns the counter, address 2 returns {RSTCTL[7:5], 5'b0}, and address 3 returns 0x00. The upper byte of writes to addresses 0 and 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data; upper byte is the key for address 2 |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_o | output | 1 | Interval overflow interrupt (level) |
| rst_pulse_o | output | 1 | Watchdog reset pulse |
| rst_kind_o | output | 1 | Kind of the reset in progress |

## Verification
The hardest case to reach from the ports is an overflow that lands in exactly the same cycle as a software write touching the same flag. The counter wraps only after hundreds of prescaler ticks. The bench therefore shrinks the prescaler through `BASE_SHIFT`, preloads the counter close to 0xFF, and counts clocks from the counter write so that the flag-clearing write lands on the wrap edge. Random key bytes and data patterns test the key decoding against a bench model of the three register bits, and random preload values move the wrap point for every clock-select code.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int CNT_W = 8;
    localparam int BUS_W = 16;

    localparam logic [7:0] KEY_FLAG  = 8'hA5;
    localparam logic [7:0] KEY_RESET = 8'h5A;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_RSTCTL = 2'd2,
        REG_NONE   = 2'd3
    } kwdt_reg_e;

    typedef struct packed {
        logic [2:0]       clk_sel;
        logic             run;
        logic             mode;      // 1 = watchdog, 0 = interval
        logic             ivl_flag;
        logic             wd_flag;
        logic             rst_en;
        logic             rst_sel;
        logic [CNT_W-1:0] cnt;
    } kwdt_state_t;
endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
    parameter int BASE_SHIFT = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam int PRE_W = BASE_SHIFT + 2;
    localparam logic [PRE_W-1:0] MASK_SLOW = '1;
    localparam logic [PRE_W-1:0] MASK_MID  = MASK_SLOW >> 1;
    localparam logic [PRE_W-1:0] MASK_FAST = MASK_SLOW >> 2;

    logic [PRE_W-1:0] pre_d, pre_q, mask;

    always_comb begin
        case (sel)
            3'd6:    mask = MASK_MID;
            3'd7:    mask = MASK_SLOW;
            default: mask = MASK_FAST;   // codes 0..5 use the fastest rate
        endcase
        tick = run && ((pre_q & mask) == mask);
        if (restart)  pre_d = '0;
        else if (run) pre_d = pre_q + 1'b1;
        else          pre_d = pre_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
    parameter int PULSE_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic kind_in,
    output logic active,
    output logic kind
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);

    logic [PW-1:0] cnt_d, cnt_q;
    logic          kind_d, kind_q;

    always_comb begin
        cnt_d  = cnt_q;
        kind_d = kind_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
            if (cnt_q == PW'(1)) kind_d = 1'b0;
        end else if (fire) begin
            cnt_d  = LEN;
            kind_d = kind_in;
        end
        active = (cnt_q != '0);
        kind   = kind_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            kind_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            kind_q <= kind_d;
        end
    end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int BASE_SHIFT = 10,
    parameter int PULSE_LEN  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             irq_o,
    output logic             rst_pulse_o,
    output logic             rst_kind_o
);
    kwdt_state_t s_d, s_q;
    kwdt_reg_e   reg_sel;
    logic        tick, restart, ovf, fire;
    logic [7:0]  key;

    assign reg_sel = kwdt_reg_e'(bus_addr);
    assign key     = bus_wdata[15:8];

    kwdt_prescaler #(.BASE_SHIFT(BASE_SHIFT)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.run),
        .restart (restart),
        .sel     (s_q.clk_sel),
        .tick    (tick)
    );

    kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .kind_in (s_q.rst_sel),
        .active  (rst_pulse_o),
        .kind    (rst_kind_o)
    );

    always_comb begin
        s_d     = s_q;
        restart = 1'b0;
        ovf     = tick && (s_q.cnt == '1);
        if (tick) s_d.cnt = s_q.cnt + 1'b1;

        if (bus_wr) begin
            case (reg_sel)
                REG_CTRL: begin
                    s_d.clk_sel  = bus_wdata[2:0];
                    s_d.run      = bus_wdata[3];
                    s_d.mode     = bus_wdata[4];
                    s_d.ivl_flag = s_q.ivl_flag & bus_wdata[7];
                end
                REG_COUNT: begin
                    s_d.cnt = bus_wdata[CNT_W-1:0];
                    restart = 1'b1;
                end
                REG_RSTCTL: begin
                    if (key == KEY_FLAG) begin
                        if (!bus_wdata[7]) s_d.wd_flag = 1'b0;
                    end else if (key == KEY_RESET) begin
                        s_d.rst_en  = bus_wdata[6];
                        s_d.rst_sel = bus_wdata[5];
                    end
                end
                default: ;
            endcase
        end

        // a wrap outranks a clearing write in the same cycle
        if (ovf) begin
            if (s_q.mode) s_d.wd_flag  = 1'b1;
            else          s_d.ivl_flag = 1'b1;
        end
        fire = ovf && s_q.mode && s_q.rst_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_sel)
            REG_CTRL:   bus_rdata = {s_q.ivl_flag, 2'b00, s_q.mode, s_q.run, s_q.clk_sel};
            REG_COUNT:  bus_rdata = s_q.cnt;
            REG_RSTCTL: bus_rdata = {s_q.wd_flag, s_q.rst_en, s_q.rst_sel, 5'b0};
            default:    bus_rdata = 8'h00;
        endcase
    end

    assign irq_o = s_q.ivl_flag;
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
    import kwdt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] key,
    input logic       run,
    input logic       mode,
    input logic       ivl_flag,
    input logic       wd_flag,
    input logic       rst_en,
    input logic       rst_sel,
    input logic [7:0] cnt,
    input logic       rst_pulse,
    input logic       rst_kind
);
    assert_frozen_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(bus_wr && bus_addr == 2'd1)) |=> $stable(cnt));

    assert_bad_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && key != KEY_FLAG && key != KEY_RESET)
        |=> $stable({rst_en, rst_sel}));

    assert_ivl_flag_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ivl_flag) |-> !$past(mode));

    assert_wd_flag_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> $past(mode));

    assert_pulse_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse) |-> ($past(rst_en) && $past(mode)));

    assert_kind_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pulse |-> !rst_kind);
endmodule

bind kwdt_top kwdt_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .key       (bus_wdata[15:8]),
    .run       (s_q.run),
    .mode      (s_q.mode),
    .ivl_flag  (s_q.ivl_flag),
    .wd_flag   (s_q.wd_flag),
    .rst_en    (s_q.rst_en),
    .rst_sel   (s_q.rst_sel),
    .cnt       (s_q.cnt),
    .rst_pulse (rst_pulse_o),
    .rst_kind  (rst_kind_o)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
    localparam int SHIFT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [7:0]  bus_rdata;
    logic        irq_o, rst_pulse_o, rst_kind_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    kwdt_top #(.BASE_SHIFT(SHIFT), .PULSE_LEN(128)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .rst_pulse_o(rst_pulse_o), .rst_kind_o(rst_kind_o)
    );

    function automatic int period(input int code);
        if (code == 6)      return 1 << (SHIFT + 1);
        else if (code == 7) return 1 << (SHIFT + 2);
        else                return 1 << SHIFT;
    endfunction

    function automatic logic [7:0] rst_model(input logic [7:0] cur, input logic [15:0] w);
        logic [7:0] n = cur;
        if (w[15:8] == 8'hA5) begin
            if (!w[7]) n[7] = 1'b0;
        end else if (w[15:8] == 8'h5A) begin
            n[6:5] = w[6:5];
        end
        return n;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp_rst;
        int n, w;
        void'($urandom(32'h1234_5EED));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 count", v, 8'h00);
        rd(2'd2, v); chk("R1 rstctl", v, 8'h00);
        chk("R1 outputs", {irq_o, rst_pulse_o, rst_kind_o}, 3'b000);

        // R2 R5 R6: interval overflow for each clock code, random preload
        foreach (dummy_codes[i]) begin
            int code = dummy_codes[i];
            wr(2'd0, 16'h0008 | code[15:0]);
            rd(2'd0, v); chk("R6 cleared by write 0", v[7], 1'b0);
            n = 8'hF0 + int'($urandom % 15);
            w = period(code) * (256 - n);
            wr(2'd1, n[15:0]);
            step(w - 1);
            rd(2'd0, v); chk("R2 no wrap yet", v[7], 1'b0);
            chk("R5 irq low", irq_o, 1'b0);
            step(1);
            rd(2'd0, v); chk("R2 R5 flag at wrap", v[7], 1'b1);
            chk("R5 irq high", irq_o, 1'b1);
            chk("R5 no pulse", rst_pulse_o, 1'b0);
            rd(2'd1, v); chk("R2 count wrapped", v, 8'h00);
        end

        // R6 writing 1 keeps the flag; R12 read layout and unused bits
        wr(2'd0, 16'hFFED);
        rd(2'd0, v); chk("R6 R12 ctrl keep", v, 8'h8D);
        rd(2'd3, v); chk("R12 addr3 zero", v, 8'h00);

        // R6 overflow in the same cycle as a clearing write
        wr(2'd0, 16'h000D);
        wr(2'd1, 16'h00FE);
        step(7);
        wr(2'd0, 16'h000D);
        rd(2'd0, v); chk("R6 set wins", v[7], 1'b1);

        // R4 zero restart
        wr(2'd1, 16'hAB00);
        step(3 * period(5));
        rd(2'd1, v); chk("R4 count from zero", v, 8'h03);

        // R3 freeze then resume
        wr(2'd0, 16'h0005);
        wr(2'd1, 16'h0010);
        step(50);
        rd(2'd1, v); chk("R3 frozen", v, 8'h10);
        wr(2'd0, 16'h000D);
        step(period(5) - 1);
        rd(2'd1, v); chk("R3 R2 before first tick", v, 8'h10);
        step(1);
        rd(2'd1, v); chk("R3 R2 resumed", v, 8'h11);

        // R7 R11: watchdog wrap with reset disabled
        wr(2'd0, 16'h001D);
        wr(2'd1, 16'h00FE);
        step(2 * period(5));
        rd(2'd2, v); chk("R7 wd flag", v, 8'h80);
        rd(2'd0, v); chk("R7 ctrl flag untouched", v[7], 1'b0);
        chk("R7 irq low", irq_o, 1'b0);
        chk("R11 disabled no pulse", rst_pulse_o, 1'b0);
        wr(2'd0, 16'h0010);

        // R8 R9 R10 directed keys
        exp_rst = 8'h80;
        wr(2'd2, 16'hA580);
        rd(2'd2, v); chk("R8 bit7=1 keeps flag", v, exp_rst);
        wr(2'd2, 16'h5A60); exp_rst = 8'hE0;
        rd(2'd2, v); chk("R9 enable and kind", v, exp_rst);
        wr(2'd2, 16'h3300);
        rd(2'd2, v); chk("R10 bad key ignored", v, exp_rst);
        wr(2'd2, 16'hA57F); exp_rst = 8'h60;
        rd(2'd2, v); chk("R8 clear flag", v, exp_rst);

        // R8 R9 R10 random keys
        for (int i = 0; i < 40; i++) begin
            logic [15:0] d;
            int pick = int'($urandom % 3);
            d[7:0] = 8'($urandom);
            if (pick == 0)      d[15:8] = 8'hA5;
            else if (pick == 1) d[15:8] = 8'h5A;
            else                d[15:8] = 8'($urandom);
            wr(2'd2, d);
            exp_rst = rst_model(exp_rst, d);
            rd(2'd2, v); chk("R8 R9 R10 random key", v, exp_rst);
        end

        // R11 pulse length and kind
        wr(2'd0, 16'h001D);
        for (int k = 1; k >= 0; k--) begin
            wr(2'd2, 16'h5A40 | (16'(k) << 5));
            wr(2'd1, 16'h00FE);
            step(2 * period(5) - 1);
            chk("R11 no pulse before wrap", rst_pulse_o, 1'b0);
            step(1);
            chk("R11 pulse starts", {rst_pulse_o, rst_kind_o}, {1'b1, 1'(k)});
            step(127);
            chk("R11 pulse last cycle", {rst_pulse_o, rst_kind_o}, {1'b1, 1'(k)});
            step(1);
            chk("R11 pulse ended", {rst_pulse_o, rst_kind_o}, 2'b00);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int dummy_codes[4] = '{5, 6, 7, 2};
endmodule